// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Command Sequencer

This block sits on the host side of a parallel NOR flash bus. A requester hands it one operation at a time: program a word, erase one sector, or erase the whole array. The block drives the bus pins itself. It issues the unlock and command write cycles of the standard single-supply command set, holding each write-enable pulse and the gap after it for a set number of clock cycles. It then reads the target location again and again until bit 7 of every selected byte lane shows completion. When that happens it reports success. If the polling window runs out first, it reports a timeout.

The data bus is 32 bits wide and is made of four independent byte-wide devices. Each lane has its own chip select and write enable, and a request carries a lane mask that selects which devices take part. Every timing value is a parameter in clock cycles, rounded up from the device's nanosecond minimums. The defaults assume a 125 MHz clock and the fastest speed grade. The timeout default is scaled down for simulation.

Operation codes on `req_op` are: 0 = program, 1 = sector erase, 2 or 3 = chip erase.

Top module: `nor_prog_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, every `fl_cs_n`, `fl_we_n` and `fl_oe_n` bit is high, `fl_dq_oe` is 0, `busy` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle through the cycle in which `done` or `err` pulses. `req_ready` is low whenever `busy` is high. `done` and `err` are one-cycle pulses and never occur together.
- R3: Op 0 (program) issues exactly four writes as (address, byte): (555h, AAh), (2AAh, 55h), (555h, A0h), and then (target, request data). In the last write the full 32-bit request word goes on the bus.
- R4: Op 1 (sector erase) issues exactly six writes: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), and then (target,30h).
- R5: Op 2 and op 3 (chip erase) issue the same first five writes as R4, and the sixth write is (555h,10h).
- R6: Each write holds write enable low for exactly WE_LOW_CYC cycles. Between two writes it stays high for at least WE_HIGH_CYC cycles. Two consecutive falling edges are at least WCYC_CYC cycles apart. Address and data do not change while write enable is low, and the data bus is driven for the whole low phase.
- R7: Chip select and write enable go low only on the lanes set in `req_lanes`, and always together as the full mask. A command byte appears on all four byte lanes of `fl_dq_out`.
- R8: After the last write, the block reads the target address with the data bus released. It completes after the first read in which bit 7 of every selected lane matches the expected value: the programmed byte's bit 7 for a program, 1 for an erase. Lanes outside the mask are ignored.
- R9: Output enable is never low while any write enable is low. Output enable stays high for at least OE_REC_CYC cycles between two reads, and after the final read before the result pulse.
- R10: Each status read keeps output enable low for exactly RD_ACC_CYC cycles, and the read data is sampled at the end of that window.
- R11: If no matching read occurs within TMO_CYC cycles of polling, `err` pulses instead of `done`. The error is reported after at least TMO_CYC cycles.
- R12: A request with an all-zero lane mask asserts no chip select and no write enable, and completes with `done` after one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_addr | input | ADDR_W | Target or sector address |
| req_data | input | 8*LANES | Program data, one byte per lane |
| req_lanes | input | LANES | Byte lanes taking part |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| err | output | 1 | One-cycle pulse: polling timed out |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8*LANES | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8*LANES | Data read from the flash |
| fl_cs_n | output | LANES | Per-lane chip select, active low |
| fl_we_n | output | LANES | Per-lane write enable, active low |
| fl_oe_n | output | 1 | Shared output enable, active low |

## Verification
The hardest situation to create from the ports is a mixed poll. In such a poll, some selected lanes already show completion, others do not, and unselected lanes always show the wrong bit 7. A wrong completion rule still looks correct on a uniform device.

The bench's flash model makes this happen. On every output-enable falling edge it counts the read and returns, for each lane, a bit 7 that is deliberately wrong until a per-vector number of busy reads has passed. Unselected lanes stay wrong forever. Program data is chosen so that the expected bit 7 differs between lanes.

A vector that never turns good drives the block into its timeout path.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_CHIP  = 2'd2,
        OP_CHIP2 = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WLOW  = 3'd1,
        ST_WHIGH = 3'd2,
        ST_PRD   = 3'd3,
        ST_PGAP  = 3'd4,
        ST_FIN   = 3'd5
    } st_e;

    localparam logic [7:0]  BYTE_KEY_A   = 8'hAA;
    localparam logic [7:0]  BYTE_KEY_B   = 8'h55;
    localparam logic [7:0]  BYTE_WRITE   = 8'hA0;
    localparam logic [7:0]  BYTE_ARM     = 8'h80;
    localparam logic [7:0]  BYTE_ALL     = 8'h10;
    localparam logic [7:0]  BYTE_BLOCK   = 8'h30;
    localparam logic [11:0] LOC_KEY_A    = 12'h555;
    localparam logic [11:0] LOC_KEY_B    = 12'h2AA;
    localparam int          STEPS_PROG   = 4;
    localparam int          STEPS_ERASE  = 6;

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANES  = 4,
    localparam int DW    = 8 * LANES,
    localparam int PAD   = ADDR_W - 12
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] target,
    input  logic [DW-1:0]     wdata,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DW-1:0]     cyc_data,
    output logic              last
);

    logic [7:0]  cmd_byte;
    logic        use_target;
    logic        use_wdata;
    logic [11:0] key_loc;

    always_comb begin
        cmd_byte   = BYTE_KEY_A;
        key_loc    = LOC_KEY_A;
        use_target = 1'b0;
        use_wdata  = 1'b0;
        unique case (step)
            3'd0: begin cmd_byte = BYTE_KEY_A; key_loc = LOC_KEY_A; end
            3'd1: begin cmd_byte = BYTE_KEY_B; key_loc = LOC_KEY_B; end
            3'd2: begin
                cmd_byte = (op == OP_PROG) ? BYTE_WRITE : BYTE_ARM;
                key_loc  = LOC_KEY_A;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    use_target = 1'b1;
                    use_wdata  = 1'b1;
                end else begin
                    cmd_byte = BYTE_KEY_A;
                    key_loc  = LOC_KEY_A;
                end
            end
            3'd4: begin cmd_byte = BYTE_KEY_B; key_loc = LOC_KEY_B; end
            default: begin
                if (op == OP_SECT) begin
                    cmd_byte   = BYTE_BLOCK;
                    use_target = 1'b1;
                end else begin
                    cmd_byte = BYTE_ALL;
                    key_loc  = LOC_KEY_A;
                end
            end
        endcase
    end

    assign cyc_addr = use_target ? target : {{PAD{1'b0}}, key_loc};
    assign last     = (op == OP_PROG) ? (step == 3'(STEPS_PROG - 1))
                                      : (step == 3'(STEPS_ERASE - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cyc_data[8*g +: 8] = use_wdata ? wdata[8*g +: 8] : cmd_byte;
    end

endmodule

// File: rtl/nor_poll_match.sv
module nor_poll_match #(
    parameter int LANES = 4,
    localparam int DW   = 8 * LANES
) (
    input  logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] lanes,
    input  logic             is_prog,
    output logic             match
);

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic want;
        assign want       = is_prog ? wdata[8*g + 7] : 1'b1;
        assign lane_ok[g] = !lanes[g] || (rdata[8*g + 7] == want);
    end

    assign match = &lane_ok;

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int LANES       = 4,
    parameter int WE_LOW_CYC  = 6,
    parameter int WE_HIGH_CYC = 3,
    parameter int WCYC_CYC    = 12,
    parameter int RD_ACC_CYC  = 12,
    parameter int OE_REC_CYC  = 2,
    parameter int OE_HOLD_CYC = 2,
    parameter int TMO_CYC     = 3000,
    localparam int DW         = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_data,
    input  logic [LANES-1:0]  req_lanes,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DW-1:0]     fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DW-1:0]     fl_dq_in,
    output logic [LANES-1:0]  fl_cs_n,
    output logic [LANES-1:0]  fl_we_n,
    output logic              fl_oe_n
);

    localparam int HI_A     = (WCYC_CYC - WE_LOW_CYC > WE_HIGH_CYC) ? (WCYC_CYC - WE_LOW_CYC) : WE_HIGH_CYC;
    localparam int WE_HI_EFF = (OE_HOLD_CYC > HI_A) ? OE_HOLD_CYC : HI_A;
    localparam int M1       = (WE_LOW_CYC > WE_HI_EFF) ? WE_LOW_CYC : WE_HI_EFF;
    localparam int M2       = (RD_ACC_CYC > OE_REC_CYC) ? RD_ACC_CYC : OE_REC_CYC;
    localparam int CNT_MAX  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int TMO_W    = $clog2(TMO_CYC + 2);

    localparam logic [CNT_W-1:0] LD_WLOW  = CNT_W'(WE_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WHIGH = CNT_W'(WE_HI_EFF - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(RD_ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(OE_REC_CYC - 1);
    localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(TMO_CYC);

    typedef struct packed {
        st_e               st;
        logic [2:0]        step;
        logic [CNT_W-1:0]  cnt;
        logic [TMO_W-1:0]  tmo;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [LANES-1:0]  lanes;
        logic              fail;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] cyc_addr;
    logic [DW-1:0]     cyc_data;
    logic              last_step;
    logic              poll_ok;

    nor_cmd_table #(.ADDR_W(ADDR_W), .LANES(LANES)) u_table (
        .op       (r_q.op),
        .step     (r_q.step),
        .target   (r_q.addr),
        .wdata    (r_q.data),
        .cyc_addr (cyc_addr),
        .cyc_data (cyc_data),
        .last     (last_step)
    );

    nor_poll_match #(.LANES(LANES)) u_match (
        .rdata   (fl_dq_in),
        .wdata   (r_q.data),
        .lanes   (r_q.lanes),
        .is_prog (r_q.op == OP_PROG),
        .match   (poll_ok)
    );

    assign busy      = (r_q.st != ST_IDLE) || r_q.done || r_q.err;
    assign req_ready = !busy;
    assign done      = r_q.done;
    assign err       = r_q.err;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    r_d.st    = ST_WLOW;
                    r_d.step  = 3'd0;
                    r_d.cnt   = LD_WLOW;
                    r_d.op    = op_e'(req_op);
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.lanes = req_lanes;
                    r_d.fail  = 1'b0;
                end
            end
            ST_WLOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_WHIGH;
                    r_d.cnt = LD_WHIGH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHIGH: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (last_step) begin
                    r_d.st  = ST_PRD;
                    r_d.cnt = LD_READ;
                    r_d.tmo = '0;
                end else begin
                    r_d.st   = ST_WLOW;
                    r_d.step = r_q.step + 3'd1;
                    r_d.cnt  = LD_WLOW;
                end
            end
            ST_PRD: begin
                if (r_q.tmo != '1) r_d.tmo = r_q.tmo + 1'b1;
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (poll_ok) begin
                    r_d.st   = ST_FIN;
                    r_d.cnt  = LD_REC;
                    r_d.fail = 1'b0;
                end else if (r_q.tmo >= TMO_LIM) begin
                    r_d.st   = ST_FIN;
                    r_d.cnt  = LD_REC;
                    r_d.fail = 1'b1;
                end else begin
                    r_d.st  = ST_PGAP;
                    r_d.cnt = LD_REC;
                end
            end
            ST_PGAP: begin
                if (r_q.tmo != '1) r_d.tmo = r_q.tmo + 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_PRD;
                    r_d.cnt = LD_READ;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_FIN: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = !r_q.fail;
                    r_d.err  = r_q.fail;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_PROG, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic in_write, in_poll;
    assign in_write = (r_q.st == ST_WLOW) || (r_q.st == ST_WHIGH);
    assign in_poll  = (r_q.st == ST_PRD) || (r_q.st == ST_PGAP);

    assign fl_cs_n   = (in_write || in_poll) ? ~r_q.lanes : '1;
    assign fl_we_n   = (r_q.st == ST_WLOW) ? ~r_q.lanes : '1;
    assign fl_oe_n   = (r_q.st != ST_PRD);
    assign fl_dq_oe  = in_write;
    assign fl_addr   = in_write ? cyc_addr : (in_poll ? r_q.addr : '0);
    assign fl_dq_out = in_write ? cyc_data : '0;

endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [8*LANES-1:0] fl_dq_out,
    input logic              fl_dq_oe,
    input logic [LANES-1:0]  fl_cs_n,
    input logic [LANES-1:0]  fl_we_n,
    input logic              fl_oe_n
);

    a_r2_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && busy));

    a_r2_result_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));

    a_r2_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r6_bus_stable_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((fl_we_n != '1) && $past(fl_we_n != '1)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    a_r6_driven_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n != '1) |-> fl_dq_oe);

    a_r7_we_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fl_we_n) & fl_cs_n) == '0);

    a_r8_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

    a_r9_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && (fl_we_n != '1)));

endmodule

bind nor_prog_seq nor_prog_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_cs_n   (fl_cs_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/nor_prog_seq_test.sv
`timescale 1ns/1ps
module nor_prog_seq_test;

    localparam int T_WLOW = 6;
    localparam int T_WHI  = 3;
    localparam int T_WC   = 12;
    localparam int T_RD   = 12;
    localparam int T_REC  = 2;
    localparam int T_TMO  = 3000;
    localparam int NV     = 6;

    // {op, addr, data, lanes, busy_reads, expect_err}
    localparam logic [74:0] VEC [NV] = '{
        {2'd0, 20'h12345, 32'hA5C3_7E01, 4'hF, 16'd3,     1'b0},
        {2'd1, 20'h40000, 32'h0,         4'hF, 16'd5,     1'b0},
        {2'd2, 20'h00000, 32'h0,         4'h5, 16'd2,     1'b0},
        {2'd3, 20'h0ABCD, 32'h0,         4'hF, 16'd0,     1'b0},
        {2'd0, 20'hFFFFF, 32'h0000_8000, 4'h2, 16'd1,     1'b0},
        {2'd0, 20'h00777, 32'h8001_7F80, 4'hF, 16'hFFFF,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lanes = '0;
    logic        busy, done, err;
    logic [19:0] fl_addr;
    logic [31:0] fl_dq_out;
    logic        fl_dq_oe;
    logic [31:0] fl_dq_in = '0;
    logic [3:0]  fl_cs_n, fl_we_n;
    logic        fl_oe_n;

    always #4 clk = ~clk;

    nor_prog_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes),
        .busy(busy), .done(done), .err(err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int total = 0;
    int bad   = 0;

    // stimulus context read by the flash model
    logic [1:0]  cur_op;
    logic [19:0] cur_addr;
    logic [31:0] cur_data;
    logic [3:0]  cur_lanes;
    int          cur_reads;

    // monitor state
    logic        in_op = 1'b0, prev_we = 1'b0, prev_oe = 1'b0;
    int          nwr, low_run, low_bad, hi_run, min_hi, since_fall, min_period;
    int          lane_bad, bus_bad, busy_bad, npoll, oe_run, oe_w_bad, oe_hi_run;
    int          min_oe_gap, fin_gap, poll_bad, cs_seen;
    logic [19:0] wr_addr [8];
    logic [31:0] wr_data [8];
    logic [19:0] hold_a;
    logic [31:0] hold_d;

    function automatic logic [31:0] model_read(input int n);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            logic want, good;
            want = (cur_op == 2'd0) ? cur_data[8*k+7] : 1'b1;
            good = cur_lanes[k] && (n > cur_reads);
            v[8*k +: 8] = {good ? want : ~want, 7'h2A};
        end
        return v;
    endfunction

    always @(negedge clk) begin
        logic we_any, oe_low;
        we_any = (fl_we_n != 4'hF);
        oe_low = !fl_oe_n;
        if (!rst_n) begin
            in_op = 1'b0;
        end else if (req_valid && req_ready) begin
            in_op = 1'b1;
            nwr = 0; low_bad = 0; min_hi = 999; min_period = 999; since_fall = 0;
            lane_bad = 0; bus_bad = 0; busy_bad = 0; npoll = 0; oe_w_bad = 0;
            min_oe_gap = 999; fin_gap = 0; poll_bad = 0; oe_hi_run = 0; hi_run = 0;
            low_run = 0; cs_seen = 0;
        end else if (in_op) begin
            if (done || err) begin
                in_op = 1'b0;
                fin_gap = oe_hi_run;
            end
            if (!busy) busy_bad++;
            if (req_ready) busy_bad++;
            if (fl_cs_n != 4'hF) begin
                cs_seen++;
                if (fl_cs_n != ~cur_lanes) lane_bad++;
            end
            if (we_any) begin
                if (!prev_we) begin
                    if (nwr < 8) begin
                        wr_addr[nwr] = fl_addr;
                        wr_data[nwr] = fl_dq_out;
                    end
                    nwr++;
                    if (nwr > 1 && since_fall < min_period) min_period = since_fall;
                    if (nwr > 1 && hi_run < min_hi) min_hi = hi_run;
                    since_fall = 0;
                    low_run = 0;
                    hold_a = fl_addr;
                    hold_d = fl_dq_out;
                end else if (fl_addr != hold_a || fl_dq_out != hold_d) begin
                    bus_bad++;
                end
                if (!fl_dq_oe) bus_bad++;
                if (fl_we_n != ~cur_lanes) lane_bad++;
                low_run++;
            end else begin
                if (prev_we) begin
                    if (low_run != T_WLOW) low_bad++;
                    hi_run = 0;
                end
                hi_run++;
            end
            since_fall++;
            if (oe_low) begin
                if (!prev_oe) begin
                    npoll++;
                    if (npoll > 1 && oe_hi_run < min_oe_gap) min_oe_gap = oe_hi_run;
                    oe_run = 0;
                    fl_dq_in = model_read(npoll);
                end
                oe_run++;
                if (fl_addr != cur_addr || fl_dq_oe) poll_bad++;
            end else begin
                if (prev_oe) begin
                    if (oe_run != T_RD) oe_w_bad++;
                    oe_hi_run = 0;
                end
                oe_hi_run++;
            end
        end
        prev_we = we_any;
        prev_oe = oe_low;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [51:0] exp_wr(input logic [1:0] op, input int i,
                                          input logic [19:0] a, input logic [31:0] d);
        logic [19:0] ea;
        logic [7:0]  b;
        logic        full;
        full = 1'b0; ea = 20'h555; b = 8'hAA;
        case (i)
            0: begin ea = 20'h555; b = 8'hAA; end
            1: begin ea = 20'h2AA; b = 8'h55; end
            2: begin ea = 20'h555; b = (op == 2'd0) ? 8'hA0 : 8'h80; end
            3: if (op == 2'd0) begin ea = a; full = 1'b1; end
               else begin ea = 20'h555; b = 8'hAA; end
            4: begin ea = 20'h2AA; b = 8'h55; end
            default: if (op == 2'd1) begin ea = a; b = 8'h30; end
                     else begin ea = 20'h555; b = 8'h10; end
        endcase
        return {ea, full ? d : {4{b}}};
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [19:0] a, input logic [31:0] d,
                          input logic [3:0] ln, input int reads, input logic exp_err, input int vi);
        int  wait_cyc;
        int  nexp;
        logic got_done, got_err;
        cur_op = op; cur_addr = a; cur_data = d; cur_lanes = ln; cur_reads = reads;
        fl_dq_in = '0;
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_lanes = ln; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R2 busy after accept", busy, 1);
        wait_cyc = 1; got_done = 0; got_err = 0;
        while (!(done || err) && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        got_done = done; got_err = err;
        chk(busy, "R2 busy during result pulse", busy, 1);
        @(negedge clk);
        chk(!done && !err && !busy && req_ready, "R2 single pulse then idle",
            {done, err, busy, req_ready}, 4'b0001);
        chk(busy_bad == 0, "R2 busy/ready held during op", busy_bad, 0);
        if (exp_err) begin
            chk(got_err && !got_done, "R11 timeout reported", {got_done, got_err}, 2'b01);
            chk(wait_cyc >= T_TMO && wait_cyc < T_TMO + 300, "R11 timeout delay", wait_cyc, T_TMO);
        end else begin
            chk(got_done && !got_err, $sformatf("R8 completion vec%0d", vi), {got_done, got_err}, 2'b10);
            chk(npoll == reads + 1, $sformatf("R8 read count vec%0d", vi), npoll, reads + 1);
        end
        nexp = (op == 2'd0) ? 4 : 6;
        if (ln == 4'h0) begin
            chk(cs_seen == 0 && nwr == 0, "R12 no lane asserted", cs_seen, 0);
        end else begin
            chk(nwr == nexp, $sformatf("R3 R4 R5 write count vec%0d", vi), nwr, nexp);
            for (int i = 0; i < nexp && i < 8; i++) begin
                logic [51:0] e;
                e = exp_wr(op, i, a, d);
                chk({wr_addr[i], wr_data[i]} == e,
                    $sformatf("%s write %0d vec%0d", (op == 2'd0) ? "R3" : ((op == 2'd1) ? "R4" : "R5"), i, vi),
                    {wr_addr[i], wr_data[i]}, e);
            end
            chk(low_bad == 0, "R6 write pulse width", low_bad, 0);
            chk(min_hi >= T_WHI, "R6 high time between writes", min_hi, T_WHI);
            chk(min_period >= T_WC, "R6 write cycle period", min_period, T_WC);
            chk(bus_bad == 0, "R6 bus stable and driven", bus_bad, 0);
            chk(lane_bad == 0, "R7 lane enables follow mask", lane_bad, 0);
        end
        chk(poll_bad == 0, "R8 read address and bus release", poll_bad, 0);
        chk(oe_w_bad == 0, "R10 read window width", oe_w_bad, 0);
        if (npoll > 1) chk(min_oe_gap >= T_REC, "R9 recovery between reads", min_oe_gap, T_REC);
        chk(fin_gap >= T_REC, "R9 recovery before result", fin_gap, T_REC);
    endtask

    initial begin
        logic wd;
        wd = 1'b0;
        fork
            begin
                // R1 reset state
                repeat (3) @(negedge clk);
                chk(fl_cs_n == 4'hF && fl_we_n == 4'hF && fl_oe_n && !fl_dq_oe && !busy,
                    "R1 outputs in reset", {fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe, busy}, 11'h7FC);
                rst_n = 1'b1;
                @(negedge clk);
                chk(req_ready && !busy && fl_cs_n == 4'hF && fl_oe_n,
                    "R1 idle after reset", {req_ready, busy}, 2'b10);

                for (int v = 0; v < NV; v++) begin
                    logic [74:0] t;
                    t = VEC[v];
                    run_op(t[74:73], t[72:53], t[52:21], t[20:17], int'(t[16:1]), t[0], v);
                end

                // R12 empty lane mask
                run_op(2'd0, 20'h00100, 32'hFFFF_FFFF, 4'h0, 0, 1'b0, 90);

                // R1 reset in the middle of a write burst
                cur_lanes = 4'hF; cur_addr = 20'h3; cur_op = 2'd2; cur_reads = 0;
                @(negedge clk);
                req_op = 2'd2; req_addr = 20'h3; req_lanes = 4'hF; req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
                while (nwr < 2) @(negedge clk);
                rst_n = 1'b0;
                #1;
                chk(fl_cs_n == 4'hF && fl_we_n == 4'hF && fl_oe_n && !fl_dq_oe && !busy,
                    "R1 mid-operation reset", {fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe, busy}, 11'h7FC);
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                chk(req_ready && !busy, "R1 ready after second reset", {req_ready, busy}, 2'b10);

                // normal operation afterwards, mixed lanes with differing bit 7
                run_op(2'd0, 20'h0F0F0, 32'h7F80_00FF, 4'hB, 2, 1'b0, 91);
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule